// File: doc/BRIEF.md
# Clock-Follower Serial Character Receiver

This block receives characters from a two-wire clocked serial link on which an external master drives the clock. Both link lines are brought into the system clock domain through a short flop chain. Each falling edge of the link clock shifts one data bit into an assembly register, least significant bit first. Once the configured number of bits has arrived, the finished character is written into a small receive queue. The block then reports that data is waiting and, if enabled, raises an interrupt request.

Software-style controls choose between 8-bit and 9-bit characters and gate the receiver. A read strobe removes the oldest character from the queue. The ninth bit of the oldest character appears on its own output next to the low eight bits, so it must be read before that character is removed. Reception never pauses between characters while enabled. An overrun flag latches when a character completes with no room left in the queue, and from then on reception is frozen until the flag is cleared.

Top module: `ssr_slave_rx`

## Requirements
- R1: Characters are received only while `port_en`=1, `sync_mode`=1 and `clk_master`=0. With any other combination, link activity leaves `rx_ready` low.
- R2: A data bit is taken on each falling edge of `ser_clk`. The first bit taken is bit 0 of the character.
- R3: With `nine_bit`=0 a character is 8 bits long and `rd_bit9` reads 0 for it. With `nine_bit`=1 a character is 9 bits long and its last bit appears on `rd_bit9`.
- R4: Characters are accepted back to back with no re-arming in between, and `single_rx` has no effect on reception or on the queue.
- R5: `rx_ready` is 1 exactly while the queue holds at least one character. A one-cycle `rd_pop` removes the oldest character, and `rd_pop` on an empty queue changes nothing.
- R6: The queue holds two characters and returns them in arrival order. `rd_data` and `rd_bit9` always show the oldest character.
- R7: `irq` equals `rx_ie` AND `rx_ready`.
- R8: When a character completes while the queue is full, that character is discarded and `overrun` becomes 1. While `overrun` is 1, every further character is discarded, even after reads have made room.
- R9: Driving `rx_en` to 0 clears `overrun` and discards a partly received character. The queue contents are kept.
- R10: Driving `port_en` to 0 empties the queue, clears `overrun` and discards a partial character.
- R11: After `rst`, `rx_ready`, `overrun` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable; 0 resets the receiver |
| sync_mode | input | 1 | 1 selects clocked (synchronous) link mode |
| clk_master | input | 1 | 1 selects clock-driving role; must be 0 for this receiver |
| rx_en | input | 1 | Continuous receive enable; 0 clears overrun |
| single_rx | input | 1 | Single-character request; ignored |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| rx_ie | input | 1 | Receive interrupt enable |
| ser_clk | input | 1 | Link clock from the external master |
| ser_dat | input | 1 | Link data line |
| rd_pop | input | 1 | Read strobe; removes the oldest character |
| rd_data | output | 8 | Low eight bits of the oldest character |
| rd_bit9 | output | 1 | Ninth bit of the oldest character |
| rx_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Latched overrun error |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest condition to reach from the ports is the frozen state after an overrun. To get there, two characters must sit unread in the queue, a third must then complete, and reads must follow that free space while `overrun` stays set. Only then can the test show that a fourth character is still dropped. The random phase sends bursts of one to three characters of mixed lengths before draining the queue, so it reaches full-queue overruns again and again. A directed sequence adds a read after the overrun and then a further character, to show that the freeze holds even when there is room.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int CHAR_LO_W = 8;
  localparam int CHAR_W    = CHAR_LO_W + 1;

  typedef struct packed {
    logic                 ninth;
    logic [CHAR_LO_W-1:0] low;
  } ssr_char_t;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lnk_clk,
  input  logic lnk_dat,
  output logic fall,
  output logic dat_s
);
  logic [STAGES:0]   clk_chain;
  logic [STAGES-1:0] dat_chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_chain[g] <= 1'b1;
          dat_chain[g] <= 1'b0;
        end else if (g == 0) begin
          clk_chain[g] <= lnk_clk;
          dat_chain[g] <= lnk_dat;
        end else begin
          clk_chain[g] <= clk_chain[g-1];
          dat_chain[g] <= dat_chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_chain[STAGES] <= 1'b1;
    else     clk_chain[STAGES] <= clk_chain[STAGES-1];
  end

  assign fall  = clk_chain[STAGES] & ~clk_chain[STAGES-1];
  assign dat_s = dat_chain[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      sample,
  input  logic      bit_in,
  input  logic      nine_bit,
  output logic      done,
  output ssr_char_t char_out
);
  localparam int CNT_W = $clog2(CHAR_W);

  logic [CHAR_W-1:0] asm_q;
  logic [CHAR_W-1:0] asm_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = nine_bit ? CNT_W'(CHAR_W - 1) : CNT_W'(CHAR_LO_W - 1);

  always_comb begin
    asm_nx        = asm_q;
    asm_nx[cnt_q] = bit_in;
    if (!nine_bit) asm_nx[CHAR_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      asm_q    <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      char_out <= '0;
    end else begin
      done <= 1'b0;
      if (sample) begin
        if (cnt_q == last_idx) begin
          char_out <= ssr_char_t'(asm_nx);
          done     <= 1'b1;
          cnt_q    <= '0;
          asm_q    <= '0;
        end else begin
          asm_q <= asm_nx;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssr_fifo.sv
module ssr_fifo
  import ssr_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  ssr_char_t wdata,
  input  logic      pop,
  output ssr_char_t rdata,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ssr_char_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/ssr_slave_rx.sv
module ssr_slave_rx
  import ssr_pkg::*;
#(
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 port_en,
  input  logic                 sync_mode,
  input  logic                 clk_master,
  input  logic                 rx_en,
  input  logic                 single_rx,
  input  logic                 nine_bit,
  input  logic                 rx_ie,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 rd_pop,
  output logic [CHAR_LO_W-1:0] rd_data,
  output logic                 rd_bit9,
  output logic                 rx_ready,
  output logic                 overrun,
  output logic                 irq
);
  logic      blk_rst;
  logic      run;
  logic      fall, dat_s;
  logic      done;
  ssr_char_t new_char, head;
  logic      q_empty, q_full;
  logic      push, pop;

  assign blk_rst = rst | ~port_en;
  assign run     = port_en & sync_mode & ~clk_master & rx_en;

  ssr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(blk_rst), .lnk_clk(ser_clk), .lnk_dat(ser_dat),
    .fall(fall), .dat_s(dat_s)
  );

  ssr_shifter shift_i (
    .clk(clk), .rst(blk_rst), .clr(~run), .sample(fall), .bit_in(dat_s),
    .nine_bit(nine_bit), .done(done), .char_out(new_char)
  );

  assign push = done & run & ~overrun & ~q_full;
  assign pop  = rd_pop & ~q_empty;

  ssr_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(blk_rst), .push(push), .wdata(new_char), .pop(pop),
    .rdata(head), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (blk_rst || !rx_en)             overrun <= 1'b0;
    else if (done && run && q_full)    overrun <= 1'b1;
  end

  assign rd_data  = head.low;
  assign rd_bit9  = head.ninth;
  assign rx_ready = ~q_empty;
  assign irq      = rx_ie & ~q_empty;
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk (
  input logic clk,
  input logic rst,
  input logic port_en,
  input logic sync_mode,
  input logic clk_master,
  input logic rx_en,
  input logic single_rx,
  input logic rd_pop,
  input logic rx_ready,
  input logic overrun
);
  AST_PORT_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!rx_ready && !overrun)); // R10

  AST_RXEN_CLEARS_OVR: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !overrun); // R9

  AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_ready)); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && port_en && rx_en) |=> overrun); // R8

  AST_READY_NEEDS_SLAVE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(port_en && sync_mode && !clk_master && rx_en)); // R1

  AST_SINGLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && single_rx && port_en && !rd_pop) |=> rx_ready); // R4
endmodule

bind ssr_slave_rx ssr_rx_chk chk_i (
  .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
  .clk_master(clk_master), .rx_en(rx_en), .single_rx(single_rx),
  .rd_pop(rd_pop), .rx_ready(rx_ready), .overrun(overrun)
);

// File: tb/ssr_slave_rx_tb.sv
`timescale 1ns/1ps
module ssr_slave_rx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b0, sync_mode = 1'b1, clk_master = 1'b0, rx_en = 1'b0;
  logic single_rx = 1'b0, nine_bit = 1'b0, rx_ie = 1'b0;
  logic ser_clk = 1'b1, ser_dat = 1'b0, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit9, rx_ready, overrun, irq;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  int   m_cnt = 0;
  logic [8:0] m_q [2];
  bit   m_ovr = 1'b0;

  always #2.5 clk = ~clk;

  ssr_slave_rx dut_i (
    .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
    .clk_master(clk_master), .rx_en(rx_en), .single_rx(single_rx),
    .nine_bit(nine_bit), .rx_ie(rx_ie), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rx_ready(rx_ready), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] shape(input logic [8:0] v, input bit nine);
    return nine ? v : {1'b0, v[7:0]};
  endfunction

  function automatic bit is_slave(input bit pe, input bit sm, input bit cm, input bit re);
    return pe && sm && !cm && re;
  endfunction

  task automatic model_rx(input logic [8:0] v);
    if (!is_slave(port_en, sync_mode, clk_master, rx_en)) return;
    if (m_ovr) return;
    if (m_cnt == 2) begin m_ovr = 1'b1; return; end
    m_q[m_cnt] = shape(v, nine_bit);
    m_cnt++;
  endtask

  task automatic send(input logic [8:0] v);
    int nb = nine_bit ? 9 : 8;
    for (int b = 0; b < nb; b++) begin
      ser_dat = v[b];
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
    end
    repeat (8) @(negedge clk);
    model_rx(v);
  endtask

  task automatic pop;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
    if (m_cnt > 0) begin
      m_q[0] = m_q[1];
      m_cnt--;
    end
  endtask

  task automatic check_head(input string req);
    chk(req, rx_ready, m_cnt > 0);
    if (m_cnt > 0) begin
      chk(req, rd_data, m_q[0][7:0]);
      chk(req, rd_bit9, m_q[0][8]);
    end
  endtask

  task automatic drain(input string req);
    while (m_cnt > 0) begin
      check_head(req);
      pop();
    end
    chk(req, rx_ready, 0);
  endtask

  task automatic clear_ovr;
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    m_ovr = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready", rx_ready, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 irq", irq, 0);

    port_en = 1'b1; rx_en = 1'b1;
    clk_master = 1'b1;
    send(9'h0A5);
    chk("R1 master role blocks", rx_ready, 0);
    clk_master = 1'b0; sync_mode = 1'b0;
    send(9'h05A);
    chk("R1 async mode blocks", rx_ready, 0);
    sync_mode = 1'b1;

    send(9'h001);
    check_head("R2 lsb first");
    pop();
    chk("R5 pop empties", rx_ready, 0);
    pop();
    chk("R5 pop on empty", rx_ready, 0);

    nine_bit = 1'b1;
    send(9'h1C3);
    check_head("R3 nine bit");
    pop();
    nine_bit = 1'b0;
    send(9'h13C);
    check_head("R3 eight bit ninth zero");

    chk("R7 irq masked", irq, 0);
    rx_ie = 1'b1;
    @(negedge clk);
    chk("R7 irq on", irq, 1);
    pop();
    chk("R7 irq off empty", irq, 0);

    single_rx = 1'b1;
    send(9'h011); send(9'h022);
    single_rx = 1'b0;
    check_head("R4 single_rx ignored");
    chk("R6 two held", overrun, 0);
    send(9'h033);
    chk("R8 overrun set", overrun, 1);
    pop();
    send(9'h044);
    chk("R8 frozen after read", overrun, 1);
    check_head("R8 frozen head");
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    m_ovr = 1'b0;
    chk("R9 overrun cleared", overrun, 0);
    check_head("R9 queue kept");
    rx_en = 1'b1;
    drain("R6 order");

    ser_dat = 1'b1;
    for (int b = 0; b < 4; b++) begin
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      repeat (4) @(negedge clk); ser_clk = 1'b1;
    end
    rx_en = 1'b0; repeat (2) @(negedge clk); rx_en = 1'b1;
    repeat (2) @(negedge clk);
    send(9'h096);
    check_head("R9 partial discarded");
    pop();

    send(9'h077);
    port_en = 1'b0;
    repeat (2) @(negedge clk);
    m_cnt = 0; m_ovr = 1'b0;
    chk("R10 queue emptied", rx_ready, 0);
    port_en = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      int n;
      nine_bit = $urandom % 2;
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) send(9'($urandom));
      chk("R8 random overrun", overrun, m_ovr);
      drain("R6 random order");
      if (m_ovr) begin
        clear_ovr();
        chk("R9 random clear", overrun, 0);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule